// File: doc/BRIEF.md
# Eight-Entry Word FIFO with Wrapping Level

This block is a synchronous first-in first-out store of eight words, nine bits each. A serial engine uses one copy for the words it sends and another for the words it receives. A producer pushes a word with a write strobe. A consumer always sees the oldest stored word on the read-data output and removes it with a read strobe.

The occupancy is reported on a level field only three bits wide. That field counts 0 to 7 and wraps back to 0 once all eight slots are in use. A separate full flag therefore tells a full store from an empty one. A consumer that finds the full flag set may remove exactly eight words. A producer computes its free room as eight minus the level, and only while the full flag is clear. A half flag marks four or more stored words.

A synchronous clear input empties the store in a single cycle. The surrounding controller raises it as its soft-reset step, after the receive side has been drained.

Top module: `ring9_fifo`

## Requirements
- R1: After the asynchronous active-low reset, level reads 0 and the full and half flags are both low.
- R2: On the clock edge after a request, level shows the stored count modulo eight in 3 bits, so it reads 0 with eight words stored.
- R3: The full flag is high exactly when eight words are stored.
- R4: The half flag is high exactly when four or more words are stored.
- R5: Whenever at least one word is stored, rdData shows the oldest stored word, and an accepted read removes that word.
- R6: A write is accepted only if fewer than eight words were stored before the edge. A refused write changes neither the count nor the stored words.
- R7: A read is accepted only if at least one word was stored before the edge. A read of an empty store leaves it empty.
- R8: When a read and a write are both accepted in the same cycle, the count does not change and the written word joins the tail.
- R9: A high softClr empties the store at the next edge and overrides any read or write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| softClr | input | 1 | Synchronous clear of the whole store |
| wrEn | input | 1 | Push strobe |
| wrData | input | 9 | Word to push |
| rdEn | input | 1 | Pop strobe |
| rdData | output | 9 | Oldest stored word (show-ahead) |
| level | output | 3 | Stored count modulo eight |
| full | output | 1 | Eight words stored |
| half | output | 1 | Four or more words stored |

## Verification
Every strobe takes effect at the next rising edge, and level, full and half are decoded from the updated count with no further register. They are therefore due one edge after the request. The bench drives inputs on the falling edge, lets one rising edge pass, and compares the flags 1 ns later against its queue model. rdData depends only on stored state, so it is compared in the half cycle before the edge that consumes it.

// File: rtl/ring9_pkg.sv
package ring9_pkg;
  // strobes sent from the control module to the storage datapath
  typedef struct packed {
    logic push;   // store wrData at the write slot
    logic pop;    // oldest slot is released
    logic clear;  // drop all contents
  } ring9Strobe_t;
endpackage

// File: rtl/ring9_ctrl.sv
module ring9_ctrl
  import ring9_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              softClr,
  input  logic              wrEn,
  input  logic              rdEn,
  output ring9Strobe_t      strb,
  output logic [ADDR_W-1:0] wrPtr,
  output logic [ADDR_W-1:0] rdPtr,
  output logic [ADDR_W-1:0] level,
  output logic              full,
  output logic              half
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = ADDR_W + 1;
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(DEPTH / 2);

  logic [CNT_W-1:0] count;
  logic             isEmpty;

  assign isEmpty = (count == '0);
  assign full    = (count == FULL_CNT);
  assign half    = (count >= HALF_CNT);
  // level deliberately keeps only the low bits and wraps at DEPTH
  assign level   = count[ADDR_W-1:0];

  // acceptance is judged on the state before the edge
  always_comb begin
    strb.clear = softClr;
    strb.push  = wrEn && !full && !softClr;
    strb.pop   = rdEn && !isEmpty && !softClr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
      wrPtr <= '0;
      rdPtr <= '0;
    end else if (strb.clear) begin
      count <= '0;
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strb.push) wrPtr <= ADDR_W'(wrPtr + 1'b1);
      if (strb.pop)  rdPtr <= ADDR_W'(rdPtr + 1'b1);
      case ({strb.push, strb.pop})
        2'b10:   count <= CNT_W'(count + 1'b1);
        2'b01:   count <= CNT_W'(count - 1'b1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/ring9_store.sv
module ring9_store
  import ring9_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  ring9Strobe_t      strb,
  input  logic [ADDR_W-1:0] wrPtr,
  input  logic [ADDR_W-1:0] rdPtr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] slots [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        slots[g] <= '0;
      else if (strb.push && (wrPtr == ADDR_W'(g)))
        slots[g] <= wrData;
    end
  end

  // show-ahead: oldest word is always presented
  assign rdData = slots[rdPtr];
endmodule

// File: rtl/ring9_fifo.sv
module ring9_fifo
  import ring9_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              softClr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] level,
  output logic              full,
  output logic              half
);
  ring9Strobe_t      strb;
  logic [ADDR_W-1:0] wrPtr;
  logic [ADDR_W-1:0] rdPtr;

  ring9_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .softClr(softClr), .wrEn(wrEn), .rdEn(rdEn),
    .strb(strb), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .level(level), .full(full), .half(half)
  );

  ring9_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uStore (
    .clk(clk), .rstN(rstN), .strb(strb), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: rtl/ring9_fifo_chk.sv
module ring9_fifo_chk #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 9
) (
  input logic              clk,
  input logic              rstN,
  input logic              softClr,
  input logic              wrEn,
  input logic              rdEn,
  input logic [DATA_W-1:0] rdData,
  input logic [ADDR_W-1:0] level,
  input logic              full,
  input logic              half
);
  logic isEmpty;
  assign isEmpty = !full && (level == '0);

  // R2: wrapped level reads zero when eight words are held
  p_level_wrap_r2: assert property (@(posedge clk) disable iff (!rstN)
    full |-> (level == '0));

  // R3: full can only appear after a write request
  p_full_rise_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(full) |-> $past(wrEn));

  // R4: a full store is also at least half full
  p_half_r4: assert property (@(posedge clk) disable iff (!rstN)
    full |-> half);

  // R6: a lone write into a full store changes nothing
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rstN)
    (full && wrEn && !rdEn && !softClr) |=> (full && $stable(rdData)));

  // R7: a lone read of an empty store keeps it empty
  p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rstN)
    (isEmpty && rdEn && !wrEn && !softClr) |=> (level == '0 && !full));

  // R8: accepted read plus write holds the count
  p_keep_count_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!isEmpty && !full && wrEn && rdEn && !softClr) |=>
      ($stable(level) && !full));

  // R9: clear empties the store at the next edge
  p_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    softClr |=> (level == '0 && !full && !half));
endmodule

bind ring9_fifo ring9_fifo_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .softClr(softClr), .wrEn(wrEn), .rdEn(rdEn),
  .rdData(rdData), .level(level), .full(full), .half(half)
);

// File: tb/ring9_fifo_test.sv
module ring9_fifo_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       softClr = 1'b0;
  logic       wrEn = 1'b0;
  logic [8:0] wrData = '0;
  logic       rdEn = 1'b0;
  logic [8:0] rdData;
  logic [2:0] level;
  logic       full;
  logic       half;

  int nChecks = 0;
  int nFails = 0;
  bit [8:0] model[$];

  always #2 clk = ~clk;  // 250 MHz

  ring9_fifo uut (
    .clk(clk), .rstN(rstN), .softClr(softClr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .level(level), .full(full), .half(half)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int expLevel(int n); return n % 8; endfunction
  function automatic int expFull(int n);  return (n == 8) ? 1 : 0; endfunction
  function automatic int expHalf(int n);  return (n >= 4) ? 1 : 0; endfunction

  task automatic checkFlags();
    check("R2 level", int'(level), expLevel(model.size()));
    check("R3 full", int'(full), expFull(model.size()));
    check("R4 half", int'(half), expHalf(model.size()));
  endtask

  // one cycle: drive on falling edge, check after the rising edge
  task automatic step(input bit w, input bit r, input bit c, input bit [8:0] d);
    bit takeW, takeR;
    @(negedge clk);
    wrEn = w; rdEn = r; softClr = c; wrData = d;
    if (model.size() > 0) check("R5 head", int'(rdData), int'(model[0]));
    takeW = w && (model.size() < 8) && !c;
    takeR = r && (model.size() > 0) && !c;
    @(posedge clk);
    #1;
    if (c) model.delete();
    else begin
      if (takeR) void'(model.pop_front());
      if (takeW) model.push_back(d);
    end
    checkFlags();
  endtask

  initial begin : watchdog
    #(4 * 150000);
    nFails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1234));
    #7;
    // R1: reset state
    check("R1 level", int'(level), 0);
    check("R1 full", int'(full), 0);
    check("R1 half", int'(half), 0);
    @(negedge clk);
    rstN = 1'b1;

    // R7: read of empty store
    step(0, 1, 0, 9'h000);
    check("R7 stays empty", int'(level) + int'(full), 0);

    // fill to eight; R2 wrap at eight
    for (int i = 0; i < 8; i++) step(1, 0, 0, 9'(9'h100 + i));
    check("R2 level wraps to 0", int'(level), 0);
    check("R3 full at eight", int'(full), 1);

    // R6: write when full refused, even with a read in the same cycle
    step(1, 0, 0, 9'h0AA);
    check("R6 full kept", int'(full), 1);
    step(1, 1, 0, 9'h0BB);
    check("R6 write refused with read", int'(level), 7);

    // R5: drain in order
    for (int i = 0; i < 7; i++) step(0, 1, 0, 9'h000);
    check("R5 drained", int'(level), 0);

    // R8: simultaneous read and write
    step(1, 0, 0, 9'h011);
    step(1, 0, 0, 9'h022);
    step(1, 1, 0, 9'h033);
    check("R8 count held", int'(level), 2);
    step(1, 1, 0, 9'h044);
    check("R8 tail order", int'(rdData), 9'h033);

    // R9: clear beats a write
    step(1, 0, 1, 9'h1FF);
    check("R9 cleared", int'(level) + int'(full) + int'(half), 0);

    // constrained random traffic
    for (int i = 0; i < 3000; i++) begin
      int u;
      u = int'($urandom_range(99));
      step(u < 55, (u % 3) != 0, u == 7, 9'($urandom));
    end

    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule